// File: doc/BRIEF.md
# AC-link Controller Frame Sequencer

This block is the controller end of a serial audio codec link. It runs entirely from the 12.288 MHz bit clock, which is half of a 24.576 MHz master clock, and builds a 256-bit frame every 256 bit periods, giving 48 kHz. Each frame opens with a 16-bit tag slot and carries twelve 20-bit data slots. The block drives the frame marker `sync_o` and one outgoing serial line shared by every attached codec. It also collects up to four independent return lines, one per codec, into parallel per-codec slot registers. The surrounding logic supplies the outgoing tag and slot words in parallel and gets back the captured slots, a per-codec ready flag and a one-cycle frame strobe.

Timing is controlled by a three-state sequencer. `ST_HALT` is the reset state. `ST_TAG` covers bit periods 0 to 15, and the marker is high throughout. `ST_SLOT` covers bit periods 16 to 255, and the marker is low. The transitions are: launch (`ST_HALT` to `ST_TAG` on the first rising edge after reset release), tag-done (`ST_TAG` to `ST_SLOT` after bit 15), and wrap (`ST_SLOT` to `ST_TAG` after bit 255). `ST_TAG` and `ST_SLOT` hold themselves otherwise.

Outgoing bits change on rising clock edges. Incoming bits are sampled on the falling edge in the middle of each bit period.

Top module: `aclink_framer`

## Requirements
- R1: While `rst_n` is low, `sync_o`, `sdata_o`, `frame_stb`, `codec_rdy`, `rx_tag` and `rx_slots` are all held at zero.
- R2: A frame lasts exactly 256 bit periods. `sync_o` is high for the first 16 bit periods of each frame and low for the remaining 240.
- R3: The first frame begins at the first rising edge after reset release. In that first bit period, `sync_o` is high and `sdata_o` carries `tx_tag[15]`.
- R4: `sdata_o` sends the 256-bit word {`tx_tag`, `tx_slots`} most significant bit first, one bit per period. Bit period 0 carries `tx_tag[15]`. Slot 1 is `tx_slots[239:220]` and goes out in periods 16 to 35. Slot 12 is `tx_slots[19:0]` and goes out last.
- R5: `tx_tag` and `tx_slots` are taken only at the rising edge that starts a frame. Changing them later in that frame has no effect on the bits sent in that frame.
- R6: Each `sdata_i[c]` is sampled on the falling edge within each bit period. At the end of the frame, bit period 0 lands in `rx_tag[c*16+15]` and bit period 255 lands in `rx_slots[c*240]`, using the same slot layout as R4.
- R7: `codec_rdy[c]` equals the bit received from line c in bit period 0, which is bit 15 of input slot 0. Each line's flag is independent of the others.
- R8: `frame_stb` is high for exactly one clock, on the rising edge that ends bit period 255. That edge is also the one where `sync_o` rises for the next frame. `codec_rdy`, `rx_tag` and `rx_slots` change only on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_tag | input | 16 | Outgoing slot-0 word |
| tx_slots | input | 240 | Outgoing slots 1..12, slot 1 in the top 20 bits |
| sdata_i | input | 4 | One serial return line per codec |
| sync_o | output | 1 | Frame marker |
| sdata_o | output | 1 | Shared outgoing serial data |
| frame_stb | output | 1 | One-clock end-of-frame strobe |
| codec_rdy | output | 4 | Per-codec ready flag (slot 0, bit 15) |
| rx_tag | output | 64 | Captured slot 0, 16 bits per codec, codec c at [c*16 +: 16] |
| rx_slots | output | 960 | Captured slots 1..12, 240 bits per codec, codec c at [c*240 +: 240] |

## Verification
The bench builds the block with its default parameters. These are four codec lines, a 16-bit tag, twelve 20-bit slots and a 16-period marker, so the frame is exactly 256 bits and the full 48 kHz framing can be checked bit for bit. With four independent return lines, the bench can give each line a different ready bit and a different slot pattern, and so catch any crossing between lines or any sharing of the ready flags. With the 256-bit frame, the bench can change the outgoing words partway through a frame and observe that the frame already on the wire is unaffected.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    // Link sequencer states
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,   // held in reset, link idle
        ST_TAG  = 2'd1,   // marker high, slot 0 on the wire
        ST_SLOT = 2'd2    // marker low, data slots on the wire
    } lnk_state_e;

endpackage

// File: rtl/aclink_seq.sv
module aclink_seq
    import aclink_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int SYNC_LEN   = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,    // next rising edge starts a frame
    output logic wrap_o,    // current period is the last of the frame
    output logic run_o,     // link is framing
    output logic sync_o,
    output logic stb_o
);

    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] TAG_END  = CW'(SYNC_LEN - 1);

    lnk_state_e state_q, state_d;
    logic [CW-1:0] bit_q, bit_d;
    logic sync_q, stb_q;

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_HALT: begin
                state_d = ST_TAG;           // launch
                bit_d   = '0;
            end
            ST_TAG: begin
                bit_d = bit_q + 1'b1;
                if (bit_q == TAG_END) begin
                    state_d = ST_SLOT;      // tag-done
                end
            end
            ST_SLOT: begin
                if (bit_q == LAST_BIT) begin
                    state_d = ST_TAG;       // wrap
                    bit_d   = '0;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_HALT;
                bit_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            sync_q <= (state_d == ST_TAG);
            stb_q  <= wrap_o;
        end
    end

    assign wrap_o = (state_q == ST_SLOT) && (bit_q == LAST_BIT);
    assign load_o = (state_q == ST_HALT) || wrap_o;
    assign run_o  = (state_q != ST_HALT);
    assign sync_o = sync_q;
    assign stb_o  = stb_q;

endmodule

// File: rtl/aclink_tx.sv
module aclink_tx #(
    parameter int FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic                  sdata_o
);

    logic [FRAME_BITS-1:0] sh_q;
    logic                  bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
        end else if (load_i) begin
            bit_q <= frame_i[FRAME_BITS-1];
            sh_q  <= {frame_i[FRAME_BITS-2:0], 1'b0};
        end else begin
            bit_q <= sh_q[FRAME_BITS-1];
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign sdata_o = bit_q;

endmodule

// File: rtl/aclink_rx.sv
module aclink_rx #(
    parameter int TAG_BITS  = 16,
    parameter int BODY_BITS = 240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 wrap_i,
    input  logic                 sdata_i,
    output logic [TAG_BITS-1:0]  tag_o,
    output logic [BODY_BITS-1:0] body_o,
    output logic                 rdy_o
);

    localparam int FB = TAG_BITS + BODY_BITS;

    logic [FB-1:0]        sh_q;
    logic [TAG_BITS-1:0]  tag_q;
    logic [BODY_BITS-1:0] body_q;
    logic                 rdy_q;

    // Mid-period sampling on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (run_i) begin
            sh_q <= {sh_q[FB-2:0], sdata_i};
        end
    end

    // Whole-frame update at the frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            body_q <= '0;
            rdy_q  <= 1'b0;
        end else if (wrap_i) begin
            tag_q  <= sh_q[FB-1 -: TAG_BITS];
            body_q <= sh_q[BODY_BITS-1:0];
            rdy_q  <= sh_q[FB-1];
        end
    end

    assign tag_o  = tag_q;
    assign body_o = body_q;
    assign rdy_o  = rdy_q;

endmodule

// File: rtl/aclink_framer.sv
module aclink_framer #(
    parameter int NUM_CODECS = 4,
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int NUM_SLOTS  = 12,
    parameter int SYNC_LEN   = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TAG_BITS-1:0]             tx_tag,
    input  logic [NUM_SLOTS*SLOT_BITS-1:0]  tx_slots,
    input  logic [NUM_CODECS-1:0]           sdata_i,
    output logic                            sync_o,
    output logic                            sdata_o,
    output logic                            frame_stb,
    output logic [NUM_CODECS-1:0]           codec_rdy,
    output logic [NUM_CODECS*TAG_BITS-1:0]  rx_tag,
    output logic [NUM_CODECS*NUM_SLOTS*SLOT_BITS-1:0] rx_slots
);

    localparam int BODY_BITS  = NUM_SLOTS * SLOT_BITS;
    localparam int FRAME_BITS = TAG_BITS + BODY_BITS;

    logic load, wrap, run;

    aclink_seq #(
        .FRAME_BITS(FRAME_BITS),
        .SYNC_LEN  (SYNC_LEN)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load_o(load),
        .wrap_o(wrap),
        .run_o (run),
        .sync_o(sync_o),
        .stb_o (frame_stb)
    );

    aclink_tx #(
        .FRAME_BITS(FRAME_BITS)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .frame_i({tx_tag, tx_slots}),
        .sdata_o(sdata_o)
    );

    for (genvar c = 0; c < NUM_CODECS; c++) begin : g_rx
        aclink_rx #(
            .TAG_BITS (TAG_BITS),
            .BODY_BITS(BODY_BITS)
        ) u_rx (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run),
            .wrap_i (wrap),
            .sdata_i(sdata_i[c]),
            .tag_o  (rx_tag[c*TAG_BITS +: TAG_BITS]),
            .body_o (rx_slots[c*BODY_BITS +: BODY_BITS]),
            .rdy_o  (codec_rdy[c])
        );
    end

endmodule

// File: rtl/aclink_framer_chk.sv
module aclink_framer_chk #(
    parameter int NUM_CODECS = 4,
    parameter int FRAME_BITS = 256,
    parameter int SYNC_LEN   = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sync_o,
    input logic                  sdata_o,
    input logic                  frame_stb,
    input logic [NUM_CODECS-1:0] codec_rdy
);

    int   hi_cnt, lo_cnt;
    logic seen_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= 0;
            lo_cnt    <= 0;
            seen_fall <= 1'b0;
        end else begin
            hi_cnt <= sync_o ? hi_cnt + 1 : 0;
            lo_cnt <= sync_o ? 0 : lo_cnt + 1;
            if (!sync_o && hi_cnt != 0) seen_fall <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_QUIET: assert (!sync_o && !sdata_o && !frame_stb && codec_rdy == '0)
                else $error("outputs active during reset"); // R1
        end
    end

    AST_SYNC_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> hi_cnt == SYNC_LEN); // R2

    AST_SYNC_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_o) && seen_fall) |-> lo_cnt == FRAME_BITS - SYNC_LEN); // R2

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb); // R8

    AST_STB_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> $rose(sync_o)); // R8

    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> $stable(codec_rdy)); // R8

endmodule

bind aclink_framer aclink_framer_chk #(
    .NUM_CODECS(NUM_CODECS),
    .FRAME_BITS(FRAME_BITS),
    .SYNC_LEN  (SYNC_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_o   (sync_o),
    .sdata_o  (sdata_o),
    .frame_stb(frame_stb),
    .codec_rdy(codec_rdy)
);

// File: tb/aclink_framer_bench.sv
module aclink_framer_bench;

    localparam int NC = 4;
    localparam int TB = 16;
    localparam int SB = 20;
    localparam int NS = 12;
    localparam int BB = NS * SB;
    localparam int FB = TB + BB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [TB-1:0]    tx_tag;
    logic [BB-1:0]    tx_slots;
    logic [NC-1:0]    sd_i;
    logic             sync_o, sdata_o, frame_stb;
    logic [NC-1:0]    codec_rdy;
    logic [NC*TB-1:0] rx_tag;
    logic [NC*BB-1:0] rx_slots;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [FB-1:0] cfr [NC];
    logic [FB-1:0] cur [NC];

    aclink_framer u_aclink_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_tag   (tx_tag),
        .tx_slots (tx_slots),
        .sdata_i  (sd_i),
        .sync_o   (sync_o),
        .sdata_o  (sdata_o),
        .frame_stb(frame_stb),
        .codec_rdy(codec_rdy),
        .rx_tag   (rx_tag),
        .rx_slots (rx_slots)
    );

    // Codec models: launch one bit per period after each rising edge
    always begin
        int idx;
        logic prev;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            sd_i = '0;
            prev = 1'b0;
            idx  = FB;
        end else begin
            if (sync_o && !prev) begin
                idx = 0;
                for (int c = 0; c < NC; c++) cur[c] = cfr[c];
            end else if (idx < FB) begin
                idx++;
            end
            for (int c = 0; c < NC; c++) sd_i[c] = (idx < FB) ? cur[c][FB-1-idx] : 1'b0;
            prev = sync_o;
        end
    end

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [BB-1:0] mk_body(input logic [31:0] seed);
        logic [BB-1:0] b;
        for (int k = 0; k < NS; k++) b[k*SB +: SB] = SB'(seed + k * 32'h0001_3579);
        return b;
    endfunction

    task automatic wait_stb();
        do @(negedge clk); while (frame_stb !== 1'b1);
    endtask

    task automatic grab(output logic [FB-1:0] s, output logic [FB-1:0] d,
                        input int chg_at, input logic [TB-1:0] ntag, input logic [BB-1:0] nsl);
        for (int i = 0; i < FB; i++) begin
            if (i == chg_at) begin
                tx_tag   = ntag;
                tx_slots = nsl;
            end
            s[FB-1-i] = sync_o;
            d[FB-1-i] = sdata_o;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        tx_tag   = 16'hB3C5;
        tx_slots = mk_body(32'h0002_468A);
        repeat (5) @(negedge clk);
        chk("R1 sync_o", sync_o, 0);
        chk("R1 sdata_o", sdata_o, 0);
        chk("R1 frame_stb", frame_stb, 0);
        chk("R1 codec_rdy", codec_rdy, 0);
        chk("R1 rx_tag", rx_tag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 sync_o first period", sync_o, 1);
        chk("R3 sdata_o first bit", sdata_o, tx_tag[15]);
    endtask

    task automatic t_first_frame();
        logic [FB-1:0] s, d, exp_d;
        exp_d = {tx_tag, tx_slots};
        grab(s, d, -1, '0, '0);
        chk("R2 marker shape", s, {{16{1'b1}}, {(FB-16){1'b0}}});
        chk("R4 serial frame", d, exp_d);
        chk("R2 marker period 256", sync_o, 1);
    endtask

    task automatic t_midframe();
        logic [FB-1:0] s, d, old_f, new_f;
        logic [BB-1:0] nb;
        old_f = {tx_tag, tx_slots};
        nb    = mk_body(32'h000F_0F0F);
        new_f = {16'h4E21, nb};
        grab(s, d, 100, 16'h4E21, nb);
        chk("R5 frame unchanged by mid-frame write", d, old_f);
        grab(s, d, -1, '0, '0);
        chk("R5 new words in next frame", d, new_f);
        chk("R2 marker shape second", s, {{16{1'b1}}, {(FB-16){1'b0}}});
    endtask

    task automatic t_rx(input logic [TB-1:0] t0, input logic [TB-1:0] t1,
                        input logic [TB-1:0] t2, input logic [TB-1:0] t3,
                        input logic [31:0] seed);
        logic [TB-1:0] tg [NC];
        logic [NC-1:0] exp_rdy;
        logic [NC-1:0] rdy_snap;
        logic [NC*TB-1:0] tag_snap;
        tg[0] = t0; tg[1] = t1; tg[2] = t2; tg[3] = t3;
        for (int c = 0; c < NC; c++) begin
            cfr[c] = {tg[c], mk_body(seed ^ (32'h1111_0000 * c))};
            exp_rdy[c] = tg[c][TB-1];
        end
        wait_stb();
        wait_stb();
        for (int c = 0; c < NC; c++) begin
            chk($sformatf("R6 tag line %0d", c), rx_tag[c*TB +: TB], cfr[c][FB-1 -: TB]);
            chk($sformatf("R6 slots line %0d", c), rx_slots[c*BB +: BB], cfr[c][BB-1:0]);
        end
        chk("R7 ready flags", codec_rdy, exp_rdy);
        rdy_snap = codec_rdy;
        tag_snap = rx_tag;
        @(negedge clk);
        chk("R8 strobe one clock", frame_stb, 0);
        for (int c = 0; c < NC; c++) cfr[c] = ~cfr[c];
        repeat (120) @(negedge clk);
        chk("R8 ready held mid-frame", codec_rdy, rdy_snap);
        chk("R8 tags held mid-frame", rx_tag, tag_snap);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 act=no-finish exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            cfr[c] = '0;
            cur[c] = '0;
        end
        t_reset();
        t_first_frame();
        t_midframe();
        t_rx(16'h8123, 16'h7FFF, 16'hC001, 16'h0000, 32'h00A5_C35A);
        t_rx(16'h0F0F, 16'hFFFF, 16'h4000, 16'h0001, 32'h0013_37C0);
        t_rx(16'h8000, 16'h8000, 16'h8000, 16'h8000, 32'h0000_0000);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule